// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit logical address into a physical address by reading two levels of a page table kept in memory. The address is cut into a 12-bit outer index, a 10-bit inner index and a 10-bit byte offset within a 1 KB page. The walker first reads the outer table, whose start comes from a base register input. The outer entry points to an inner table. The walker then reads the inner entry, which holds the frame number of the page.

A processor or translation buffer hands the walker one address at a time over a valid/ready request port and takes the result from a valid/ready response port. Each result is either a physical address or a fault, and a fault carries a cause code. Range checks are done before each memory read, so a request that is out of range costs no memory traffic. The memory side is a one-cycle read strobe with an address, answered later by a data-valid strobe. Only one read is ever in flight.

Top module: `pt_walker`

## Requirements
- R1: The request address splits as outer index = bits [31:20], inner index = bits [19:10], page offset = bits [9:0].
- R2: The first memory read is at (base input with bits [1:0] forced to zero) + 4 × outer index.
- R3: If the outer index is greater than or equal to the length input, the walker responds with fault and cause 1, makes no memory read, and its response is valid in the cycle after the request is accepted.
- R4: An outer entry carries a valid flag in bit 0, the inner table length (0 to 1024) in bits [11:1], and the inner table base in bits [31:12] with its low 12 bits taken as zero. If the valid flag is clear, the walker responds with cause 2 and makes no second read.
- R5: If the inner index is greater than or equal to the inner table length of a valid outer entry, the walker responds with cause 3 and makes no second read.
- R6: The second memory read is at inner table base + 4 × inner index.
- R7: An inner entry carries a valid flag in bit 0 and a 22-bit frame number in bits [31:10]. If the valid flag is clear, the walker responds with cause 4.
- R8: A successful walk responds with fault low, cause 0 and physical address {frame number, page offset}. Any fault response has its fault flag high and a physical address of zero.
- R9: The memory read strobe lasts exactly one cycle, and no new strobe is raised until data-valid has answered the previous one.
- R10: From the acceptance of a request until its response is taken, request-ready stays low, and the response fields stay stable while response-ready is low.
- R11: After reset the walker is idle: request-ready high, response-valid low, memory read strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptbr_i | input | 32 | Byte address of the outer table |
| ptlr_i | input | 13 | Number of usable outer entries (0 to 4096) |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Logical address to translate |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_paddr_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 3 | 0 none, 1 outer range, 2 outer invalid, 3 inner range, 4 inner invalid |
| mem_req_o | output | 1 | One-cycle read strobe |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data present |
| mem_rdata_i | input | 32 | Entry read from memory |

## Verification
If the walker lost track of which level it is on, the second read would go to the wrong table, or a third strobe would appear. The bench compares every strobe address and counts the reads of each walk. These errors therefore show within one read latency of the bad transition. A controller that left the response state early, or never reached it, shows up as a response that changes under back-pressure or as a walk that never answers. Range faults are checked against a memory that saw no strobe at all. This catches a check placed after the read instead of before it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE          = 3'd0,
    CAUSE_OUTER_RANGE   = 3'd1,
    CAUSE_OUTER_INVALID = 3'd2,
    CAUSE_INNER_RANGE   = 3'd3,
    CAUSE_INNER_INVALID = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUT_REQ,
    ST_OUT_WAIT,
    ST_IN_REQ,
    ST_IN_WAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W
) (
  input  logic [VA_W-1:0]    vaddr_i,
  output logic [OUTER_W-1:0] outer_idx_o,
  output logic [INNER_W-1:0] inner_idx_o,
  output logic [OFF_W-1:0]   offset_o
);
  assign outer_idx_o = vaddr_i[VA_W-1 -: OUTER_W];
  assign inner_idx_o = vaddr_i[OFF_W +: INNER_W];
  assign offset_o    = vaddr_i[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ENTRY_W = 32,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  localparam int TBL_AL  = INNER_W + 2,
  localparam int LEN_W   = INNER_W + 1,
  localparam int FRAME_W = ENTRY_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               valid_o,
  output logic [ENTRY_W-1:0] tbl_base_o,
  output logic [LEN_W-1:0]   tbl_len_o,
  output logic [FRAME_W-1:0] frame_o
);
  // one view serves both levels; the walker picks the fields per level
  assign valid_o    = entry_i[0];
  assign tbl_base_o = {entry_i[ENTRY_W-1:TBL_AL], {TBL_AL{1'b0}}};
  assign tbl_len_o  = entry_i[TBL_AL-1:1];
  assign frame_o    = entry_i[ENTRY_W-1:OFF_W];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_fire_i,
  input  logic   outer_oob_i,
  input  logic   mem_rvalid_i,
  input  logic   ent_valid_i,
  input  logic   inner_oob_i,
  input  logic   rsp_ready_i,
  output state_e state_o,
  output cause_e cause_o,
  output logic   ld_table_o,
  output logic   ld_frame_o
);
  state_e state_q, state_d;
  cause_e cause_q, cause_d;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_IDLE: if (req_fire_i) begin
        if (outer_oob_i) begin
          state_d = ST_RESP;
          cause_d = CAUSE_OUTER_RANGE;
        end else begin
          state_d = ST_OUT_REQ;
        end
      end
      ST_OUT_REQ: state_d = ST_OUT_WAIT;
      ST_OUT_WAIT: if (mem_rvalid_i) begin
        if (!ent_valid_i) begin
          state_d = ST_RESP;
          cause_d = CAUSE_OUTER_INVALID;
        end else if (inner_oob_i) begin
          state_d = ST_RESP;
          cause_d = CAUSE_INNER_RANGE;
        end else begin
          state_d = ST_IN_REQ;
        end
      end
      ST_IN_REQ: state_d = ST_IN_WAIT;
      ST_IN_WAIT: if (mem_rvalid_i) begin
        state_d = ST_RESP;
        cause_d = ent_valid_i ? CAUSE_NONE : CAUSE_INNER_INVALID;
      end
      ST_RESP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign state_o    = state_q;
  assign cause_o    = cause_q;
  assign ld_table_o = (state_q == ST_OUT_WAIT) && mem_rvalid_i && ent_valid_i && !inner_oob_i;
  assign ld_frame_o = (state_q == ST_IN_WAIT) && mem_rvalid_i && ent_valid_i;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  parameter int ENTRY_W = 32,
  localparam int VA_W    = OUTER_W + INNER_W + OFF_W,
  localparam int LEN_W   = INNER_W + 1,
  localparam int PTLR_W  = OUTER_W + 1,
  localparam int FRAME_W = ENTRY_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRY_W-1:0] ptbr_i,
  input  logic [PTLR_W-1:0]  ptlr_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [ENTRY_W-1:0] rsp_paddr_o,
  output logic               rsp_fault_o,
  output logic [2:0]         rsp_cause_o,
  output logic               mem_req_o,
  output logic [ENTRY_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i
);
  logic [VA_W-1:0]    vaddr_q;
  logic [OUTER_W-1:0] new_outer, cur_outer;
  logic [INNER_W-1:0] new_inner, cur_inner;
  logic [OFF_W-1:0]   new_off, cur_off;
  logic               ent_valid;
  logic [ENTRY_W-1:0] ent_base;
  logic [LEN_W-1:0]   ent_len;
  logic [FRAME_W-1:0] ent_frame;
  logic [ENTRY_W-1:0] in_base_q;
  logic [FRAME_W-1:0] frame_q;
  logic               req_fire, outer_oob, inner_oob, ld_table, ld_frame;
  state_e             state;
  cause_e             cause;

  ptw_index_split #(.OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_split_new (
    .vaddr_i(req_vaddr_i), .outer_idx_o(new_outer), .inner_idx_o(new_inner), .offset_o(new_off)
  );

  ptw_index_split #(.OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_split_cur (
    .vaddr_i(vaddr_q), .outer_idx_o(cur_outer), .inner_idx_o(cur_inner), .offset_o(cur_off)
  );

  ptw_entry_decode #(.ENTRY_W(ENTRY_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_dec (
    .entry_i(mem_rdata_i), .valid_o(ent_valid), .tbl_base_o(ent_base),
    .tbl_len_o(ent_len), .frame_o(ent_frame)
  );

  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  // range checks precede the read they guard
  assign outer_oob   = {1'b0, new_outer} >= ptlr_i;
  assign inner_oob   = {1'b0, cur_inner} >= ent_len;

  ptw_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_fire_i(req_fire), .outer_oob_i(outer_oob), .mem_rvalid_i(mem_rvalid_i),
    .ent_valid_i(ent_valid), .inner_oob_i(inner_oob), .rsp_ready_i(rsp_ready_i),
    .state_o(state), .cause_o(cause), .ld_table_o(ld_table), .ld_frame_o(ld_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q   <= '0;
      in_base_q <= '0;
      frame_q   <= '0;
    end else begin
      if (req_fire) vaddr_q   <= req_vaddr_i;
      if (ld_table) in_base_q <= ent_base;
      if (ld_frame) frame_q   <= ent_frame;
    end
  end

  logic [ENTRY_W-1:0] outer_addr, inner_addr;
  assign outer_addr = (ptbr_i & ~ENTRY_W'(3)) + (ENTRY_W'(cur_outer) << 2);
  assign inner_addr = in_base_q + (ENTRY_W'(cur_inner) << 2);

  assign mem_req_o  = (state == ST_OUT_REQ) || (state == ST_IN_REQ);
  assign mem_addr_o = (state == ST_IN_REQ) ? inner_addr : outer_addr;

  assign rsp_valid_o = (state == ST_RESP);
  assign rsp_fault_o = (cause != CAUSE_NONE);
  assign rsp_cause_o = cause;
  assign rsp_paddr_o = rsp_fault_o ? '0 : {frame_q, cur_off};

  // keep the new-request split fully used
  logic unused_new;
  assign unused_new = ^{new_inner, new_off};
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  parameter int ENTRY_W = 32,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W,
  localparam int PTLR_W = OUTER_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PTLR_W-1:0]  ptlr_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [VA_W-1:0]    req_vaddr_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [ENTRY_W-1:0] rsp_paddr_o,
  input logic               rsp_fault_o,
  input logic [2:0]         rsp_cause_o,
  input logic               mem_req_o,
  input logic [ENTRY_W-1:0] mem_addr_o,
  input logic               mem_rvalid_i
);
  logic pending_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pending_q <= 1'b0;
    else if (mem_req_o)    pending_q <= 1'b1;
    else if (mem_rvalid_i) pending_q <= 1'b0;
  end

  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r9_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !mem_rvalid_i) |-> !mem_req_o);

  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_cause_o)));

  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r3_range_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && ({1'b0, req_vaddr_i[VA_W-1 -: OUTER_W]} >= ptlr_i)) |=>
      (rsp_valid_o && rsp_cause_o == 3'd1 && !mem_req_o));

  a_r8_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0 && rsp_cause_o != 3'd0));

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind pt_walker ptw_checker #(
  .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ptlr_i(ptlr_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_paddr_o(rsp_paddr_o),
  .rsp_fault_o(rsp_fault_o), .rsp_cause_o(rsp_cause_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam logic [31:0] PTBR    = 32'h0000_4003;
  localparam logic [31:0] OUT_LO  = 32'h0000_4000;
  localparam logic [31:0] IN_BASE = 32'h0100_0000;

  typedef struct packed {
    logic [11:0] oi;
    logic [9:0]  ii;
    logic [9:0]  off;
    logic [12:0] ptlr;
    logic [1:0]  lat;
    logic [2:0]  cause;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'd0,    10'd0,    10'h000, 13'd4096, 2'd1, 3'd0, 2'd2},
    '{12'd1,    10'd3,    10'h3FF, 13'd4096, 2'd2, 3'd0, 2'd2},
    '{12'd3,    10'd0,    10'h005, 13'd4096, 2'd1, 3'd2, 2'd1},
    '{12'd5,    10'd20,   10'h000, 13'd4096, 2'd3, 3'd3, 2'd1},
    '{12'd5,    10'd15,   10'h001, 13'd4096, 2'd1, 3'd0, 2'd2},
    '{12'd2,    10'd7,    10'h008, 13'd4096, 2'd2, 3'd4, 2'd2},
    '{12'd10,   10'd1,    10'h000, 13'd10,   2'd1, 3'd1, 2'd0},
    '{12'd9,    10'd1,    10'h002, 13'd10,   2'd1, 3'd0, 2'd2},
    '{12'd4094, 10'd1023, 10'h155, 13'd4096, 2'd3, 3'd0, 2'd2},
    '{12'd0,    10'd0,    10'h000, 13'd0,    2'd1, 3'd1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] ptlr = 13'd4096;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0, reads = 0, mem_lat = 1, pulse_err = 0;
  logic [31:0] ra0, ra1;
  logic [31:0] g_paddr;
  logic        g_fault;
  logic [2:0]  g_cause;
  bit done = 0;

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .ptbr_i(PTBR), .ptlr_i(ptlr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // table contents: outer i valid unless i%4==3, inner length 16 when i%8==5;
  // inner j valid unless j%16==7, frame = {i,j} ^ 22'h2A5A5
  function automatic logic [21:0] frame_of(input logic [11:0] i, input logic [9:0] j);
    return {i, j} ^ 22'h2A5A5;
  endfunction

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    logic [11:0] i;
    logic [9:0]  j;
    logic [10:0] len;
    if (a >= OUT_LO && a < OUT_LO + 32'd16384) begin
      i   = 12'((a - OUT_LO) >> 2);
      len = (i % 8 == 5) ? 11'd16 : 11'd1024;
      return (IN_BASE + {8'd0, i, 12'd0}) | {20'd0, len, (i % 4 != 3)};
    end else if (a >= IN_BASE) begin
      i = 12'((a - IN_BASE) >> 12);
      j = a[11:2];
      return {frame_of(i, j), 9'd0, (j % 16 != 7)};
    end
    return 32'hDEAD_BEE0;
  endfunction

  function automatic string ctag(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // memory responder: one read at a time, answers after mem_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] d;
        reads++;
        if (reads == 1) ra0 = mem_addr; else ra1 = mem_addr;
        d = mem_model(mem_addr);
        repeat (mem_lat) begin
          @(negedge clk);
          if (mem_req) pulse_err++;
        end
        mem_rvalid = 1'b1;
        mem_rdata  = d;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [12:0] pl, input int lat, input int hold);
    @(negedge clk);
    reads = 0; mem_lat = lat; ptlr = pl;
    req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    g_paddr = rsp_paddr; g_fault = rsp_fault; g_cause = rsp_cause;
    if (hold > 0) begin
      int r0;
      r0 = reads;
      req_vaddr = 32'h0000_0400; req_valid = 1'b1;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R10 ready low while result pending", {31'd0, req_ready}, 32'd0);
        chk("R10 result held", rsp_paddr, g_paddr);
        chk("R10 valid held", {31'd0, rsp_valid}, 32'd1);
      end
      chk("R10 no read from ignored request", reads, r0);
    end
    rsp_ready = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R11 no result in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 no strobe in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] va;
      t  = VECS[v];
      va = {t.oi, t.ii, t.off};
      walk(va, t.ptlr, int'(t.lat), 0);
      chk({ctag(t.cause), " cause"}, {29'd0, g_cause}, {29'd0, t.cause});
      chk({ctag(t.cause), " fault flag"}, {31'd0, g_fault}, {31'd0, (t.cause != 3'd0)});
      chk("R8 physical address", g_paddr,
          (t.cause == 3'd0) ? {frame_of(t.oi, t.ii), t.off} : 32'd0);
      chk({ctag(t.cause), " read count"}, reads, {30'd0, t.reads});
      if (t.reads >= 1)
        chk("R1 R2 outer entry address", ra0, OUT_LO + {18'd0, t.oi, 2'b00});
      if (t.reads == 2)
        chk("R6 inner entry address", ra1, IN_BASE + {8'd0, t.oi, 12'd0} + {20'd0, t.ii, 2'b00});
    end

    // back-pressure with a competing request, then a clean walk after it
    walk({12'd6, 10'd40, 10'h2A}, 13'd4096, 2, 4);
    chk("R10 first result", g_paddr, {frame_of(12'd6, 10'd40), 10'h2A});
    walk({12'd7, 10'd1, 10'h000}, 13'd4096, 1, 0);
    chk("R4 walk after held result", {29'd0, g_cause}, 32'd2);
    walk({12'd4095, 10'd0, 10'h000}, 13'd4095, 1, 0);
    chk("R3 index equal to length", {29'd0, g_cause}, 32'd1);
    chk("R3 no read at length", reads, 0);
    chk("R9 strobe one cycle, one in flight", pulse_err, 0);
    summary();
  end
endmodule